// File: doc/BRIEF.md
# Prescaled Fixed-Interval Pulse Generator

This block produces periodic output pulses, such as a one-pulse-per-second marker, that stay locked to a compensated time counter. The time counter is not part of the block. It advances the block through a tick strobe, which comes with the nominal tick period in nanoseconds. Each generator keeps a nanosecond count that grows by the tick period on every strobe. When the count reaches or passes its programmed interval, the generator starts a pulse.

The interval is programmed as the desired period in nanoseconds minus one tick period. The formula is prescale × tick period × divider − tick period, where divider = 1e6 × output clock (MHz) / wanted rate (Hz). As an example, a 10 ns tick with a prescale of 100 gives 1 PPS with the interval 999,999,990 (0x3B9AC9F6). The prescale value divides the tick rate into an output clock. Each pulse lasts one period of that output clock, so it spans prescale ticks rather than a single clock.

There are two or three independent generators, selected by a parameter. The first is normally set up for 1 PPS. Each generator has a one-cycle event flag beside its pulse line.

Top module: `fixed_interval_pulser`

## Requirements
- R1: After reset every pulse and event output is low, each interval is zero and each count is zero.
- R2: With interval I and tick period P, on a tick that is not a write cycle: if the count is at least I, the count returns to zero and an event fires; otherwise the count grows by P. A generator written with I therefore fires on the (ceil(I/P)+1)-th tick after the write, and every ceil(I/P)+1 ticks after that. Without a tick the count does not change.
- R3: An interval that is not a multiple of the tick period is rounded up to the next whole tick. For example, I=105 with P=10 fires every 12 ticks. The count never exceeds I+P−1, because the addition saturates at its width.
- R4: With a prescale value of 2 or more, a pulse rises in the clock cycle after the firing tick and stays high for exactly prescale ticks.
- R5: A prescale value of 0 or 1 gives a pulse exactly one tick long.
- R6: An event output is high for one clock cycle per firing, in the same cycle as the pulse rise, and the pulse is high whenever the event is high.
- R7: Writing a generator's interval (its bit of wr_en high, value on wr_data) sets the count to zero and drops that generator's pulse at the next edge. A tick in the same cycle is ignored for that generator.
- R8: An interval of zero disables the generator: it never fires and its pulse stays low.
- R9: Generators are independent. A write or a firing of one generator changes neither the count nor the pulse of another.
- R10: The pulse width is taken from the prescale value at the firing tick. Changing the prescale value while a pulse is high does not change that pulse's width, but it does set the width of the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Strobe from the compensated time counter, one per nominal period |
| tick_ns | input | PER_W | Nominal tick period in nanoseconds |
| prescale | input | PRSC_W | Output-clock divider; sets the pulse width in ticks |
| wr_en | input | NUM_GEN | Per-generator interval write strobe |
| wr_data | input | CNT_W | Interval value to write |
| pulse_o | output | NUM_GEN | Registered pulse lines |
| event_o | output | NUM_GEN | One-cycle event flag per generator |

## Verification
The bench builds the block with NUM_GEN=3, so the optional third generator runs alongside the other two. CNT_W stays at the full 32 bits, and PRSC_W is 8. Small intervals of 30 to 110 ns at a 10 ns tick give periods of 4 to 12 ticks, so several firings, rounding up, prescale changes in mid-pulse and restarts during a pulse all fit in short windows. The tick strobe is also run at half rate to show that the count and the width follow ticks and not clocks.

// File: rtl/fip_pkg.sv
package fip_pkg;

  // Width of an output pulse in ticks for a given prescale value.
  function automatic int unsigned pulse_ticks(input int unsigned prsc);
    return (prsc < 2) ? 1 : prsc;
  endfunction

  // Number of ticks between firings for an interval and a tick period.
  function automatic longint unsigned ticks_per_period(input longint unsigned ivl,
                                                       input longint unsigned per);
    return (ivl + per - 1) / per + 1;
  endfunction

endpackage

// File: rtl/fip_interval_counter.sv
module fip_interval_counter #(
  parameter int CNT_W = 32,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] tick_ns,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] ivl_q,
  output logic             fire
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Saturating add so that a large interval never wraps the count.
  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [PER_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {{(CNT_W+1-PER_W){1'b0}}, b};
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  logic enabled;
  assign enabled = (ivl_q != '0);
  assign fire    = tick && !wr_en && enabled && (cnt_q >= ivl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q <= '0;
      cnt_q <= '0;
    end else if (wr_en) begin
      ivl_q <= wr_data;
      cnt_q <= '0;
    end else if (tick) begin
      if (!enabled || fire) cnt_q <= '0;
      else                  cnt_q <= sat_add(cnt_q, tick_ns);
    end
  end

endmodule

// File: rtl/fip_width_timer.sv
module fip_width_timer #(
  parameter int PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fire,
  input  logic              restart,
  input  logic [PRSC_W-1:0] prescale,
  output logic              pulse,
  output logic              evt
);

  logic [PRSC_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      evt    <= 1'b0;
      left_q <= '0;
    end else begin
      evt <= fire;
      if (restart) begin
        pulse  <= 1'b0;
        left_q <= '0;
      end else if (fire) begin
        pulse  <= 1'b1;
        left_q <= PRSC_W'(fip_pkg::pulse_ticks(32'(prescale)));
      end else if (tick && pulse) begin
        if (left_q <= 1) begin
          pulse  <= 1'b0;
          left_q <= '0;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fixed_interval_pulser.sv
module fixed_interval_pulser #(
  parameter int NUM_GEN = 3,
  parameter int CNT_W   = 32,
  parameter int PRSC_W  = 16,
  parameter int PER_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PER_W-1:0]   tick_ns,
  input  logic [PRSC_W-1:0]  prescale,
  input  logic [NUM_GEN-1:0] wr_en,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [NUM_GEN-1:0] pulse_o,
  output logic [NUM_GEN-1:0] event_o
);

  localparam int GEN_N = (NUM_GEN < 2) ? 2 : ((NUM_GEN > 3) ? 3 : NUM_GEN);

  // Internal events brought out for the checker.
  logic [NUM_GEN-1:0]            fire_v;
  logic [NUM_GEN-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_GEN-1:0][CNT_W-1:0] ivl_all;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    if (g < GEN_N) begin : g_on
      fip_interval_counter #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .tick_ns (tick_ns),
        .wr_en   (wr_en[g]),
        .wr_data (wr_data),
        .cnt_q   (cnt_all[g]),
        .ivl_q   (ivl_all[g]),
        .fire    (fire_v[g])
      );
      fip_width_timer #(.PRSC_W(PRSC_W)) u_wid (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .fire     (fire_v[g]),
        .restart  (wr_en[g]),
        .prescale (prescale),
        .pulse    (pulse_o[g]),
        .evt      (event_o[g])
      );
    end else begin : g_off
      assign cnt_all[g] = '0;
      assign ivl_all[g] = '0;
      assign fire_v[g]  = 1'b0;
      assign pulse_o[g] = 1'b0;
      assign event_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/fip_checker.sv
module fip_checker #(
  parameter int NUM_GEN = 3,
  parameter int CNT_W   = 32,
  parameter int PER_W   = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            tick,
  input logic [NUM_GEN-1:0]              wr_en,
  input logic [NUM_GEN-1:0]              pulse_o,
  input logic [NUM_GEN-1:0]              event_o,
  input logic [NUM_GEN-1:0]              fire_v,
  input logic [NUM_GEN-1:0][CNT_W-1:0]   cnt_all,
  input logic [NUM_GEN-1:0][CNT_W-1:0]   ivl_all
);

  localparam logic [CNT_W:0] PER_SPAN = (CNT_W+1)'((1 << PER_W) - 1);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    // R2: a firing needs a tick
    p_fire_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire_v[g] |-> tick);
    // R2: without tick or write the count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en[g]) |=> $stable(cnt_all[g]));
    // R3: count bounded by interval plus one period
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ivl_all[g] != '0) |-> ({1'b0, cnt_all[g]} <= {1'b0, ivl_all[g]} + PER_SPAN));
    // R6: event lasts one cycle and comes with the pulse
    p_evt_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      event_o[g] |=> !event_o[g]);
    p_evt_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      event_o[g] |-> pulse_o[g]);
    // R7: a write restarts the generator
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[g] |=> (cnt_all[g] == '0) && !pulse_o[g]);
    // R8: zero interval never fires
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ivl_all[g] == '0) |-> !fire_v[g]);
  end

endmodule

bind fixed_interval_pulser fip_checker #(
  .NUM_GEN(NUM_GEN), .CNT_W(CNT_W), .PER_W(PER_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .wr_en   (wr_en),
  .pulse_o (pulse_o),
  .event_o (event_o),
  .fire_v  (fire_v),
  .cnt_all (cnt_all),
  .ivl_all (ivl_all)
);

// File: tb/fixed_interval_pulser_test.sv
module fixed_interval_pulser_test;

  localparam int CLK_PERIOD = 10;
  localparam int NG  = 3;
  localparam int CW  = 32;
  localparam int PW  = 8;
  localparam int TW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [TW-1:0] tick_ns = 8'd10;
  logic [PW-1:0] prescale = 8'd4;
  logic [NG-1:0] wr_en = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NG-1:0] pulse_o;
  logic [NG-1:0] event_o;

  int nchk = 0, nfail = 0;
  int tick_gap = 1;
  bit done = 0;

  int first_s [NG];
  int gap_s   [NG];
  int wid_s   [NG];
  int n_s     [NG];
  int hi_s    [NG];
  int bad6    [NG];

  always #(CLK_PERIOD/2) clk = ~clk;

  fixed_interval_pulser #(.NUM_GEN(NG), .CNT_W(CW), .PRSC_W(PW), .PER_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tick_ns(tick_ns), .prescale(prescale),
    .wr_en(wr_en), .wr_data(wr_data), .pulse_o(pulse_o), .event_o(event_o)
  );

  // Tick strobe, one every tick_gap cycles.
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (tick_gap <= 1) tick = 1'b1;
      else begin
        tick = (ph == 0);
        ph = (ph + 1) % tick_gap;
      end
    end
  end

  function automatic int exp_ticks(input int ivl, input int per);
    return (ivl + per - 1) / per + 1;
  endfunction

  function automatic int exp_wid(input int pr);
    return (pr < 2) ? 1 : pr;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int g, input int val);
    @(negedge clk);
    wr_en = '0; wr_en[g] = 1'b1; wr_data = val;
    @(negedge clk);
    wr_en = '0;
  endtask

  // Sample every generator for max cycles after the current negedge.
  task automatic observe(input int max);
    int last [NG];
    bit infirst [NG];
    bit prev_evt [NG];
    for (int g = 0; g < NG; g++) begin
      first_s[g] = -1; gap_s[g] = -1; wid_s[g] = 0; n_s[g] = 0; hi_s[g] = 0;
      bad6[g] = 0; last[g] = 0; infirst[g] = 0; prev_evt[g] = 0;
    end
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      for (int g = 0; g < NG; g++) begin
        if (event_o[g]) begin
          n_s[g]++;
          if (n_s[g] == 1) begin first_s[g] = i; infirst[g] = 1; end
          else if (n_s[g] == 2) gap_s[g] = i - last[g];
          last[g] = i;
          if (!pulse_o[g] || prev_evt[g]) bad6[g]++;
        end
        if (pulse_o[g]) begin
          hi_s[g]++;
          if (infirst[g]) wid_s[g]++;
        end else if (n_s[g] >= 1) infirst[g] = 0;
        prev_evt[g] = event_o[g];
      end
    end
  endtask

  task automatic t_reset;
    chk("R1 pulses", int'(pulse_o), 0);
    chk("R1 events", int'(event_o), 0);
    observe(20);
    chk("R1 idle gen0", n_s[0], 0);
  endtask

  task automatic t_basic;
    prescale = 4;
    wr(0, 110);
    observe(40);
    chk("R2 first firing", first_s[0], exp_ticks(110, 10));
    chk("R2 period", gap_s[0], exp_ticks(110, 10));
    chk("R4 width", wid_s[0], exp_wid(4));
    chk("R6 event shape", bad6[0], 0);
  endtask

  task automatic t_round;
    wr(1, 105);
    observe(40);
    chk("R3 rounded first", first_s[1], exp_ticks(105, 10));
    chk("R3 rounded period", gap_s[1], 12);
  endtask

  task automatic t_half_rate;
    tick_gap = 2;
    wr(0, 110);
    observe(90);
    chk("R2 half-rate period", gap_s[0], 2 * exp_ticks(110, 10));
    chk("R4 half-rate width", wid_s[0], 2 * exp_wid(4));
    tick_gap = 1;
  endtask

  task automatic t_small_prsc;
    prescale = 0;
    wr(0, 110);
    observe(30);
    chk("R5 prescale 0 width", wid_s[0], 1);
    prescale = 1;
    wr(0, 110);
    observe(30);
    chk("R5 prescale 1 width", wid_s[0], 1);
    prescale = 4;
  endtask

  task automatic t_zero;
    wr(2, 0);
    wr(0, 0);
    observe(60);
    chk("R8 no events", n_s[0] + n_s[2], 0);
    chk("R8 pulse low", hi_s[0] + hi_s[2], 0);
  endtask

  task automatic t_restart;
    prescale = 4;
    wr(0, 110);
    do @(negedge clk); while (!event_o[0]);
    wr_en = 3'b001; wr_data = 110;
    @(negedge clk);
    wr_en = '0;
    chk("R7 pulse dropped", int'(pulse_o[0]), 0);
    observe(30);
    chk("R7 restart first", first_s[0], exp_ticks(110, 10));
  endtask

  task automatic t_indep;
    wr(0, 110);
    wr(1, 50);
    wr(2, 30);
    observe(60);
    chk("R9 gen0 period", gap_s[0], exp_ticks(110, 10));
    chk("R9 gen1 period", gap_s[1], exp_ticks(50, 10));
    chk("R9 gen2 period", gap_s[2], exp_ticks(30, 10));
    chk("R6 gen2 event shape", bad6[2], 0);
    wr(2, 0);
  endtask

  task automatic t_latch;
    int w;
    prescale = 4;
    wr(0, 110);
    do @(negedge clk); while (!event_o[0]);
    prescale = 8;
    w = 1;
    @(negedge clk);
    while (pulse_o[0]) begin w++; @(negedge clk); end
    chk("R10 width kept", w, 4);
    do @(negedge clk); while (!event_o[0]);
    w = 1;
    @(negedge clk);
    while (pulse_o[0]) begin w++; @(negedge clk); end
    chk("R10 next width", w, 8);
    prescale = 4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_round();
    t_half_rate();
    t_small_prsc();
    t_zero();
    t_restart();
    t_indep();
    t_latch();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule